// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a 32-bit integer unit. It adds two operands, with or without a carry-in, or it combines them bitwise. The result goes into a target register. Three per-operation control bits then decide which status bits change:

- the carry bit,
- the overflow pair: overflow and a sticky summary overflow,
- the first 4-bit field of a 32-bit condition register.

A sequencer presents the operands, an opcode and the three control bits, and pulses a write strobe. All registers change on that clock edge. The status register is kept inside the block, so an add-with-carry picks up the carry left by an earlier operation.

The condition register is eight 4-bit fields. Field n sits at bits 4n..4n+3 when bits are counted from the MSB as bit 0. Only field 0, at `cr_q[31:28]`, is written by this unit. The other fields stay at their reset value.

The block has no state machine. It has one register stage, updated only when the write strobe is high.

Top module: `int_alu_flags`

## Requirements
- R1: An active-low asynchronous reset clears `result_q`, `xer_q` and `cr_q` to zero.
- R2: Opcode 0 (add) writes `opnd_a + opnd_b` modulo 2^32. Opcode 1 (add with carry) writes `opnd_a + opnd_b + CA`, where CA is the carry bit held before the edge.
- R3: The status register is `xer_q`, with CA at bit 0, OV at bit 1 and SO at bit 2. When `upd_ca` is high on a write, CA takes the unsigned carry out of bit 31 of the add. CA takes 0 for the other opcodes. When `upd_ca` is low, CA keeps its value.
- R4: When `ov_en` is high on a write, OV takes the signed two's-complement overflow of the add. OV takes 0 for the other opcodes. When `ov_en` is low, OV keeps its value.
- R5: SO is set on every write that sets OV. SO is never cleared except by reset.
- R6: Opcodes 2, 3 and 4 write `opnd_a & opnd_b`, `opnd_a | opnd_b` and `opnd_a ^ opnd_b`. Opcode 5 writes `~opnd_a` and ignores `opnd_b`. The spare opcodes 6 and 7 write zero.
- R7: When `rec` is high on a write, field 0 (`cr_q[31:28]`, MSB first) is loaded with LT, GT, EQ, SO. LT, GT and EQ come from a signed compare of the new result with zero, and exactly one of them is set. The SO bit copies SO as updated by the same write.
- R8: Field 0 keeps its value on writes with `rec` low. Fields 1 to 7 (`cr_q[27:0]`) always stay zero.
- R9: With `wr_en` low, no register changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe; registers update on this edge |
| op | input | 3 | Opcode: 0 add, 1 add with carry, 2 and, 3 or, 4 xor, 5 not, 6/7 spare |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| upd_ca | input | 1 | Let the write update CA |
| ov_en | input | 1 | Let the write update OV (and set SO) |
| rec | input | 1 | Let the write record the compare in field 0 |
| result_q | output | 32 | Target register |
| xer_q | output | 3 | Status register {SO, OV, CA} |
| cr_q | output | 32 | Condition register, eight 4-bit fields |

## Verification
The assertions assume the following of the inputs:
- `op`, the operands and the control bits are known values whenever `wr_en` is high.
- These inputs are settled before the sampling edge.

The stimulus meets this by driving every input on the falling edge. Random operations draw from all eight opcode codes, including the spare ones, and from all control-bit combinations. Directed cases cover the carry and overflow boundaries, the sign cases of the zero compare, and idle cycles with busy inputs.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int OP_W    = 3;
    localparam int FIELD_W = 4;

    // Status register bit positions
    localparam int XER_CA = 0;
    localparam int XER_OV = 1;
    localparam int XER_SO = 2;
    localparam int XER_W  = 3;

    // Bit positions inside a condition field (MSB first: LT, GT, EQ, SO)
    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;
    localparam int CF_SO = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NOT  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           carry_flag,
    output logic [W-1:0]   res,
    output logic           carry,
    output logic           ovf
);

    logic          cin;
    logic [W:0]    sum_zx;
    logic [W:0]    sum_sx;

    always_comb begin
        cin    = (op == OP_ADDC) ? carry_flag : 1'b0;
        sum_zx = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum_sx = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, cin};
    end

    always_comb begin
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res   = sum_zx[W-1:0];
                carry = sum_zx[W];
                ovf   = sum_sx[W] ^ sum_sx[W-1];
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_cond_field.sv
module alu_cond_field
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]       val,
    input  logic               so,
    output logic [FIELD_W-1:0] field
);

    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg         = val[W-1];
        is_zero        = (val == '0);
        field          = '0;
        field[CF_LT]   = is_neg;
        field[CF_GT]   = !is_neg && !is_zero;
        field[CF_EQ]   = is_zero;
        field[CF_SO]   = so;
    end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import int_alu_pkg::*;
#(
    parameter int W       = 32,
    parameter int NFIELDS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [OP_W-1:0]            op,
    input  logic [W-1:0]               opnd_a,
    input  logic [W-1:0]               opnd_b,
    input  logic                       upd_ca,
    input  logic                       ov_en,
    input  logic                       rec,
    output logic [W-1:0]               result_q,
    output logic [XER_W-1:0]           xer_q,
    output logic [NFIELDS*FIELD_W-1:0] cr_q
);

    localparam int CR_W = NFIELDS * FIELD_W;

    alu_op_e             op_e;
    logic [W-1:0]        core_res;
    logic                core_carry;
    logic                core_ovf;
    logic                ca_n, ov_n, so_n;
    logic [FIELD_W-1:0]  f0_new;

    assign op_e = alu_op_e'(op);

    alu_core #(.W(W)) u_core (
        .op         (op_e),
        .a          (opnd_a),
        .b          (opnd_b),
        .carry_flag (xer_q[XER_CA]),
        .res        (core_res),
        .carry      (core_carry),
        .ovf        (core_ovf)
    );

    // Next status bits
    always_comb begin
        ca_n = xer_q[XER_CA];
        ov_n = xer_q[XER_OV];
        so_n = xer_q[XER_SO];
        if (wr_en && upd_ca) begin
            ca_n = core_carry;
        end
        if (wr_en && ov_en) begin
            ov_n = core_ovf;
            so_n = xer_q[XER_SO] | core_ovf;
        end
    end

    alu_cond_field #(.W(W)) u_cond (
        .val   (core_res),
        .so    (so_n),
        .field (f0_new)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            xer_q    <= '0;
        end else if (wr_en) begin
            result_q        <= core_res;
            xer_q[XER_CA]   <= ca_n;
            xer_q[XER_OV]   <= ov_n;
            xer_q[XER_SO]   <= so_n;
        end
    end

    // One register per condition field; only field 0 is written here
    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        localparam int HI = CR_W - 1 - g * FIELD_W;
        if (g == 0) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cr_q[HI -: FIELD_W] <= '0;
                end else if (wr_en && rec) begin
                    cr_q[HI -: FIELD_W] <= f0_new;
                end
            end
        end else begin : g_idle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cr_q[HI -: FIELD_W] <= '0;
                end else begin
                    cr_q[HI -: FIELD_W] <= cr_q[HI -: FIELD_W];
                end
            end
        end
    end

    // Assertions
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == 3'd0) |=> result_q == $past(opnd_a) + $past(opnd_b)); // R2
    AST_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && upd_ca) |=> $stable(xer_q[XER_CA])); // R3
    AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ov_en) |=> $stable(xer_q[XER_OV])); // R4
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(xer_q[XER_SO])); // R5
    AST_OV_IMPLIES_SO: assert property (@(posedge clk) disable iff (!rst_n)
        xer_q[XER_OV] |-> xer_q[XER_SO]); // R5
    AST_NOT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == 3'd5) |=> result_q == ~$past(opnd_a)); // R6
    AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr_q[CR_W-1 -: 3])); // R7
    AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rec) |=> cr_q[CR_W-FIELD_W] == xer_q[XER_SO]); // R7
    AST_CR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rec) |=> $stable(cr_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(result_q) && $stable(xer_q))); // R9

endmodule

// File: tb/int_alu_flags_test.sv
module int_alu_flags_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        upd_ca = 1'b0, ov_en = 1'b0, rec = 1'b0;
    logic [31:0] result_q;
    logic [2:0]  xer_q;
    logic [31:0] cr_q;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state kept by the bench
    logic [31:0] m_res = '0;
    logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;
    logic [31:0] m_cr = '0;

    always #4 clk = ~clk;   // 125 MHz

    int_alu_flags uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .upd_ca(upd_ca),
        .ov_en(ov_en), .rec(rec), .result_q(result_q),
        .xer_q(xer_q), .cr_q(cr_q)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "result", result_q, m_res);
        chk(tag, "xer", {29'd0, xer_q}, {29'd0, m_so, m_ov, m_ca});
        chk(tag, "cr", cr_q, m_cr);
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic uc, input logic oe, input logic rc,
                          input logic we, input string tag);
        logic [63:0] s;
        logic [31:0] r;
        logic        c, v, cin;
        wr_en = we; op = o; opnd_a = a; opnd_b = b;
        upd_ca = uc; ov_en = oe; rec = rc;
        @(posedge clk);
        cin = (o == 3'd1) ? m_ca : 1'b0;
        s = {32'd0, a} + {32'd0, b} + {63'd0, cin};
        c = 1'b0; v = 1'b0;
        case (o)
            3'd0, 3'd1: begin
                r = s[31:0];
                c = s[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = ~a;
            default: r = 32'd0;
        endcase
        if (we) begin
            m_res = r;
            if (uc) m_ca = c;
            if (oe) begin
                m_ov = v;
                if (v) m_so = 1'b1;
            end
            if (rc) m_cr[31:28] = {$signed(r) < 0, $signed(r) > 0, r == 32'd0, m_so};
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // Carry out of bit 31
        run_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1, 0, 1, 1, "R3");
        // Add with carry uses CA=1
        run_op(3'd1, 32'h0000_0010, 32'h0000_0020, 1, 0, 0, 1, "R2");
        // Signed overflow sets OV and SO, record shows negative + SO
        run_op(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 0, 1, 1, 1, "R4");
        // No overflow clears OV but keeps SO (R5)
        run_op(3'd0, 32'h0000_0003, 32'h0000_0004, 0, 1, 1, 1, "R5");
        // Logical op with update-carry clears CA
        run_op(3'd2, 32'hF0F0_F0F0, 32'hFFFF_0000, 1, 1, 0, 1, "R3");
        run_op(3'd3, 32'h1200_0000, 32'h0000_0034, 0, 0, 1, 1, "R6");
        run_op(3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 0, 1, 1, "R7");
        run_op(3'd5, 32'h0000_FFFF, 32'h1234_5678, 0, 0, 1, 1, "R6");
        run_op(3'd6, 32'h1234_5678, 32'h1111_1111, 0, 0, 1, 1, "R6");
        // Record off keeps field 0
        run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 1, 1, 0, 1, "R8");
        // Strobe low: nothing changes
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, 0, "R9");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] ro;
            logic [31:0] ra, rb;
            ro = 3'($urandom);
            ra = $urandom;
            rb = $urandom;
            if ((i % 7) == 0) ra = 32'h7FFF_FFF0;
            run_op(ro, ra, rb, 1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 8) != 0, "R2/R3/R4/R5/R6/R7/R8/R9");
        end

        // Reset mid-run clears everything
        rst_n = 1'b0;
        m_res = '0; m_ca = 0; m_ov = 0; m_so = 0; m_cr = '0;
        @(negedge clk);
        check_all("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule